// File: doc/BRIEF.md
# AES Byte-Lane Round Step Unit

This unit performs one byte's share of an AES round on a 32-bit column word. Each operation takes an accumulator word, a state word, a 2-bit lane index and a 2-bit mode. It picks the indexed byte of the state word and substitutes it through the forward S-box (encrypt) or the inverse S-box (decrypt). In middle-round modes it then spreads the substituted byte into the four-byte column it contributes to MixColumns or InvMixColumns. In final-round modes the substituted byte alone is used. The contribution is rotated into the lane of the selected byte and XORed into the accumulator.

Software builds a full round column by issuing four operations with lane indices 0 to 3. The result of each operation is fed back as the next accumulator. The S-boxes are computed in GF(2^8) from one shared multiplicative inverter, not stored. The result is registered and comes with a valid flag one cycle after the request.

Top module: `aes_byte_step`

## Requirements
- R1: While rst_ni is low and after its release, valid_o is 0 and result_o is 0 until the first accepted request.
- R2: A request accepted with valid_i high at a clock edge gives valid_o high after that edge. After an edge where valid_i was low, valid_o is low.
- R3: The selected byte is state_i shifted right by 8*bsel_i, low 8 bits. The contribution is rotated left by 8*bsel_i. In final-round modes, result_o XOR acc_i can be nonzero only in byte lane bsel_i.
- R4: Mode 2'b00 (encrypt, final round) uses the forward S-box with no column spread; the byte 0x00 maps to 0x63 and 0x53 maps to 0xED.
- R5: Mode 2'b10 (decrypt, final round) uses the inverse S-box with no column spread; the byte 0x00 maps to 0x52 and 0xED maps to 0x53.
- R6: Mode 2'b01 (encrypt, middle round) spreads the substituted byte s into the word {3s, s, s, 2s}, most significant byte first.
- R7: Mode 2'b11 (decrypt, middle round) spreads s into {11s, 13s, 9s, 14s}, most significant byte first.
- R8: Doubling in GF(2^8) shifts left by one and XORs 0x1B when bit 7 of the input was set. After the forward S-box, s = 0x80 at lane 0 in mode 2'b01 with a zero accumulator gives 0x9B80801B.
- R9: result_o is acc_i XOR the rotated contribution, so every accumulator bit flips exactly where the contribution is 1.
- R10: While valid_i is low, result_o keeps its value whatever the other inputs do.
- R11: Four chained operations over lanes 0..3 from a zero accumulator give a full AES round on one column. Encrypt middle on the column that substitutes to 0x455313DB gives 0xBCA14D8E. Decrypt middle on the column that inverse-substitutes to 0xBCA14D8E gives 0x455313DB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| mode_i | input | 2 | Bit 1: decrypt; bit 0: middle round |
| bsel_i | input | 2 | Byte lane index |
| acc_i | input | 32 | Accumulator word |
| state_i | input | 32 | State word supplying the byte |
| valid_o | output | 1 | Result valid, one cycle after request |
| result_o | output | 32 | Registered accumulated result |

## Verification
The zero byte and 0x53/0xED are driven in both final-round modes. These pin the affine constants and show whether the forward and inverse paths are swapped. A substituted byte of 0x80 exposes a missing or wrong reduction constant in the doubling. A full-ones accumulator and single-lane state words at every lane separate a wrong rotation from a wrong XOR. Chained four-lane runs against a known MixColumns vector catch a mis-ordered column spread, and a pseudo-random sweep over all modes and lanes is compared against an independent search-based S-box and multiply model.

// File: rtl/aes_step_pkg.sv
package aes_step_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 4;
  localparam int WORD_W = BYTE_W * LANES;
  localparam int SEL_W  = $clog2(LANES);

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    STEP_ENC_LAST = 2'b00,
    STEP_ENC_MID  = 2'b01,
    STEP_DEC_LAST = 2'b10,
    STEP_DEC_MID  = 2'b11
  } step_mode_e;

  function automatic byte_t gf_dbl(byte_t a);
    return {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? 8'h1B : 8'h00);
  endfunction

  function automatic byte_t gf_mul(byte_t a, byte_t b);
    byte_t r = '0;
    byte_t p = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) r = r ^ p;
      p = gf_dbl(p);
    end
    return r;
  endfunction

  // a^254 by a chain of a^(2^k - 1), then one squaring
  function automatic byte_t gf_inv(byte_t a);
    byte_t r = a;
    for (int k = 0; k < BYTE_W - 2; k++) r = gf_mul(gf_mul(r, r), a);
    return gf_mul(r, r);
  endfunction

  function automatic byte_t rotl8(byte_t x, int n);
    logic [2*BYTE_W-1:0] t;
    t = {x, x} << n;
    return t[2*BYTE_W-1:BYTE_W];
  endfunction

  function automatic byte_t affine_fwd(byte_t b);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
  endfunction

  function automatic byte_t affine_inv(byte_t b);
    return rotl8(b, 1) ^ rotl8(b, 3) ^ rotl8(b, 6) ^ 8'h05;
  endfunction

  function automatic word_t rotl_lanes(word_t w, logic [SEL_W-1:0] n);
    logic [2*WORD_W-1:0] t;
    t = {w, w} << (n * BYTE_W);
    return t[2*WORD_W-1:WORD_W];
  endfunction
endpackage

// File: rtl/aes_sbox_dual.sv
module aes_sbox_dual
  import aes_step_pkg::*;
(
  input  logic  dec_i,
  input  byte_t din_i,
  output byte_t dout_o
);
  byte_t pre, inv;

  // one inverter serves both directions; affine stage moves around it
  always_comb begin
    pre    = dec_i ? affine_inv(din_i) : din_i;
    inv    = gf_inv(pre);
    dout_o = dec_i ? inv : affine_fwd(inv);
  end
endmodule

// File: rtl/aes_col_expand.sv
module aes_col_expand
  import aes_step_pkg::*;
(
  input  logic  inv_i,
  input  byte_t s_i,
  output word_t col_o
);
  byte_t s2, s4, s8;

  always_comb begin
    s2 = gf_dbl(s_i);
    s4 = gf_dbl(s2);
    s8 = gf_dbl(s4);
    if (inv_i) col_o = {s8 ^ s2 ^ s_i, s8 ^ s4 ^ s_i, s8 ^ s_i, s8 ^ s4 ^ s2};
    else       col_o = {s2 ^ s_i, s_i, s_i, s2};
  end
endmodule

// File: rtl/aes_byte_step.sv
module aes_byte_step
  import aes_step_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        mode_i,
  input  logic [SEL_W-1:0]  bsel_i,
  input  logic [WORD_W-1:0] acc_i,
  input  logic [WORD_W-1:0] state_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] result_o
);
  step_mode_e mode;
  logic       is_dec, is_mid;
  word_t      shifted, col, contrib, next_res;
  byte_t      sel_byte, sub_byte;

  assign mode     = step_mode_e'(mode_i);
  assign is_dec   = (mode == STEP_DEC_LAST) || (mode == STEP_DEC_MID);
  assign is_mid   = (mode == STEP_ENC_MID) || (mode == STEP_DEC_MID);
  assign shifted  = state_i >> (bsel_i * BYTE_W);
  assign sel_byte = shifted[BYTE_W-1:0];

  aes_sbox_dual u_sbox (
    .dec_i  (is_dec),
    .din_i  (sel_byte),
    .dout_o (sub_byte)
  );

  aes_col_expand u_expand (
    .inv_i (is_dec),
    .s_i   (sub_byte),
    .col_o (col)
  );

  assign contrib  = is_mid ? col : {{(WORD_W-BYTE_W){1'b0}}, sub_byte};
  assign next_res = acc_i ^ rotl_lanes(contrib, bsel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= next_res;
    end
  end
endmodule

// File: rtl/aes_byte_step_chk.sv
module aes_byte_step_chk
  import aes_step_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [1:0]        mode_i,
  input logic [SEL_W-1:0]  bsel_i,
  input logic [WORD_W-1:0] acc_i,
  input logic [WORD_W-1:0] state_i,
  input logic              valid_o,
  input logic [WORD_W-1:0] result_o
);
  word_t            acc_q, shifted, d;
  logic [1:0]       mode_q;
  logic [SEL_W-1:0] bsel_q, back;
  byte_t            byte_q;

  assign shifted = state_i >> (bsel_i * BYTE_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      mode_q <= '0;
      bsel_q <= '0;
      byte_q <= '0;
    end else if (valid_i) begin
      acc_q  <= acc_i;
      mode_q <= mode_i;
      bsel_q <= bsel_i;
      byte_q <= shifted[BYTE_W-1:0];
    end
  end

  assign back = '0 - bsel_q;
  assign d    = rotl_lanes(result_o ^ acc_q, back);

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R2
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R2
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o)); // R10
  AST_FINAL_ONE_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !mode_q[0]) |-> (d[WORD_W-1:BYTE_W] == '0)); // R3
  AST_ENC_ZERO_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && mode_q == 2'b00 && byte_q == 8'h00) |-> (d == 32'h63)); // R4
  AST_DEC_ZERO_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && mode_q == 2'b10 && byte_q == 8'h00) |-> (d == 32'h52)); // R5
  AST_FWD_COL_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && mode_q == 2'b01) |->
      (d[15:8] == d[23:16] && d[31:24] == (d[7:0] ^ d[15:8]))); // R6
endmodule

bind aes_byte_step aes_byte_step_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .mode_i   (mode_i),
  .bsel_i   (bsel_i),
  .acc_i    (acc_i),
  .state_i  (state_i),
  .valid_o  (valid_o),
  .result_o (result_o)
);

// File: tb/aes_byte_step_test.sv
`timescale 1ns/1ps
module aes_byte_step_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vin = 1'b0;
  logic [1:0]  mode = '0;
  logic [1:0]  bsel = '0;
  logic [31:0] acc = '0;
  logic [31:0] st = '0;
  logic        valid_o;
  logic [31:0] result_o;

  int n_checks = 0;
  int n_err = 0;
  logic [7:0] fwd_t [256];
  logic [7:0] inv_t [256];

  always #2 clk = ~clk;

  aes_byte_step uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vin), .mode_i(mode), .bsel_i(bsel),
    .acc_i(acc), .state_i(st), .valid_o(valid_o), .result_o(result_o)
  );

  function automatic logic [7:0] t_mul(logic [7:0] a, logic [7:0] b);
    logic [15:0] p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011B << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] t_sub(logic [7:0] x);
    logic [7:0] b = 8'h00, o;
    for (int y = 1; y < 256; y++) if (t_mul(x, 8'(y)) == 8'h01) b = 8'(y);
    for (int i = 0; i < 8; i++)
      o[i] = b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8] ^ ((8'h63 >> i) & 8'h01) != 0;
    return o;
  endfunction

  function automatic logic [31:0] ref_step(logic [31:0] a, logic [31:0] s, logic [1:0] b, logic [1:0] m);
    logic [7:0]  x, y;
    logic [31:0] c;
    logic [63:0] r;
    x = 8'(s >> (8 * b));
    y = m[1] ? inv_t[x] : fwd_t[x];
    if (!m[0])     c = {24'h0, y};
    else if (m[1]) c = {t_mul(y, 8'd11), t_mul(y, 8'd13), t_mul(y, 8'd9), t_mul(y, 8'd14)};
    else           c = {t_mul(y, 8'd3), y, y, t_mul(y, 8'd2)};
    r = {c, c} << (8 * b);
    return a ^ r[63:32];
  endfunction

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] a, input logic [31:0] s, input logic [1:0] b,
                      input logic [1:0] m, output logic [31:0] r, output logic v);
    @(negedge clk);
    acc = a; st = s; bsel = b; mode = m; vin = 1'b1;
    @(negedge clk);
    vin = 1'b0;
    r = result_o;
    v = valid_o;
  endtask

  task automatic t_reset;
    check32("R1 valid_o in reset", 32'(valid_o), 32'h0);
    check32("R1 result_o in reset", result_o, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check32("R1 valid_o after release", 32'(valid_o), 32'h0);
    check32("R1 result_o after release", result_o, 32'h0);
  endtask

  task automatic t_known_sbox;
    logic [31:0] r; logic v;
    step(32'h0, 32'h0, 2'd0, 2'b00, r, v);
    check32("R4 enc 00->63", r, 32'h63);
    check32("R2 valid_o after request", 32'(v), 32'h1);
    step(32'h0, 32'h53, 2'd0, 2'b00, r, v);
    check32("R4 enc 53->ED", r, 32'hED);
    step(32'h0, 32'h0, 2'd0, 2'b10, r, v);
    check32("R5 dec 00->52", r, 32'h52);
    step(32'h0, 32'hED, 2'd0, 2'b10, r, v);
    check32("R5 dec ED->53", r, 32'h53);
  endtask

  task automatic t_lanes;
    logic [31:0] r; logic v;
    for (int b = 0; b < 4; b++) begin
      step(32'h0, 32'h53 << (8 * b), 2'(b), 2'b00, r, v);
      check32("R3 lane select and rotate", r, 32'hED << (8 * b));
    end
    step(32'h0, 32'h00530000, 2'd1, 2'b00, r, v);
    check32("R3 other lane ignored", r, 32'h00006300);
  endtask

  task automatic t_accumulate;
    logic [31:0] r; logic v;
    step(32'hFFFFFFFF, 32'h0, 2'd1, 2'b00, r, v);
    check32("R9 xor into ones", r, 32'hFFFF9CFF);
    step(32'h12345678, 32'h0, 2'd3, 2'b10, r, v);
    check32("R9 xor into pattern", r, 32'h40345678);
  endtask

  task automatic t_doubling;
    logic [31:0] r; logic v;
    step(32'h0, {24'h0, inv_t[8'h80]}, 2'd0, 2'b01, r, v);
    check32("R8 reduction on bit 7", r, 32'h9B80801B);
    step(32'h0, {24'h0, fwd_t[8'h01]}, 2'd0, 2'b11, r, v);
    check32("R7 dec spread of 01", r, 32'h0B0D090E);
    step(32'h0, {24'h0, inv_t[8'h01]}, 2'd0, 2'b01, r, v);
    check32("R6 enc spread of 01", r, 32'h03010102);
  endtask

  task automatic t_hold;
    logic [31:0] r, r2; logic v;
    step(32'hA5A5A5A5, 32'h0, 2'd2, 2'b00, r, v);
    @(negedge clk); acc = 32'hFFFFFFFF; st = 32'h12345678; mode = 2'b11; bsel = 2'd3;
    repeat (3) @(negedge clk);
    r2 = result_o;
    check32("R10 result holds when idle", r2, r);
    check32("R2 valid_o low when idle", 32'(valid_o), 32'h0);
  endtask

  task automatic t_column;
    logic [31:0] r, a, s; logic v;
    a = 32'h0;
    s = {inv_t[8'h45], inv_t[8'h53], inv_t[8'h13], inv_t[8'hDB]};
    for (int b = 0; b < 4; b++) begin step(a, s, 2'(b), 2'b01, r, v); a = r; end
    check32("R11 encrypt column round", a, 32'hBCA14D8E);
    a = 32'h0;
    s = {fwd_t[8'hBC], fwd_t[8'hA1], fwd_t[8'h4D], fwd_t[8'h8E]};
    for (int b = 0; b < 4; b++) begin step(a, s, 2'(b), 2'b11, r, v); a = r; end
    check32("R11 decrypt column round", a, 32'h455313DB);
  endtask

  task automatic t_sweep;
    logic [31:0] r, a, s, x; logic v;
    x = 32'h2545F491;
    for (int i = 0; i < 48; i++) begin
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5); a = x;
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5); s = x;
      step(a, s, 2'((i / 4) % 4), 2'(i % 4), r, v);
      case (i % 4)
        0: check32("R4 sweep enc final", r, ref_step(a, s, 2'((i / 4) % 4), 2'(i % 4)));
        1: check32("R6 sweep enc middle", r, ref_step(a, s, 2'((i / 4) % 4), 2'(i % 4)));
        2: check32("R5 sweep dec final", r, ref_step(a, s, 2'((i / 4) % 4), 2'(i % 4)));
        default: check32("R7 sweep dec middle", r, ref_step(a, s, 2'((i / 4) % 4), 2'(i % 4)));
      endcase
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      fwd_t[i] = t_sub(8'(i));
      inv_t[fwd_t[i]] = 8'(i);
    end
    repeat (3) @(negedge clk);
    t_reset();
    t_known_sbox();
    t_lanes();
    t_accumulate();
    t_doubling();
    t_hold();
    t_column();
    t_sweep();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule